// File: doc/BRIEF.md
# Two-channel serial interrupt controller

This block produces the interrupt request and the acknowledge vector for a two-channel serial communications controller. Each channel reports receive events through the flags of the character at the head of its receive FIFO. These flags are character available, parity error, overrun and end of frame. Each channel also reports a transmit-buffer-empty pulse and up to six external/status event pulses. A small register port sets up each channel and the single shared vector. The settings for each channel are the receive interrupt mode, parity as a special condition, parity checking, the transmit interrupt enable, the external/status master enable and the per-source enables.

When a character with a special condition reaches the head of the FIFO in any enabled receive mode, the block freezes it there. It blocks the host's FIFO read, and it raises a special-condition interrupt that lasts until an error-reset command. After the command, exactly that character may be read. The request is a registered level. During an acknowledge cycle the block drives the stored vector. If the status option is on, a 3-bit code for the highest-priority pending source is placed in that vector.

Top module: `sio_irq_ctrl`

## Requirements
- R1: After reset, irq is 0, vec_reg is 0, all channel settings are 0 (receive mode off), so rx_pop follows rx_pop_req combinationally. Register map at wr_addr: 0 = channel control {mie[4], tx_ie[3], par_special[2], rx_mode[1:0]}, 1 = parity check enable [0], 2 = external source enables [5:0], 3 = shared vector, 4 = vector control {status_high[1], vis[0]}, 5 = command {channel reset[3], external reset[2], transmit reset[1], error reset[0]}.
- R2: In rx_mode 11, an available character with no overrun, end-of-frame or qualifying parity error never raises irq and can be read.
- R3: In any rx_mode other than 00, a head character with overrun or end of frame raises irq. From the same cycle on, rx_pop stays 0 until an error reset. After that reset one read of that character passes, and irq falls.
- R4: A parity error is a special condition only when par_special and parity check enable are both 1. If parity checking is off, par_special has no effect.
- R5: In rx_mode 01 or 10, an available error-free character raises irq until rx_avail falls. In rx_mode 00 no receive interrupt occurs.
- R6: With tx_ie 1, a tx_empty pulse raises irq until a tx_load pulse or a transmit reset. With tx_ie 0 it raises nothing.
- R7: An external event raises irq only if mie and its own source enable are both 1. An external reset clears it.
- R8: A channel reset clears that channel's control, source enables and pending state, including mie, and leaves the other channel untouched.
- R9: The one vector register is written through either channel and shown on vec_reg. vec_out is 0 outside int_ack. With vis 0 it equals vec_reg during int_ack.
- R10: With vis 1, the code goes into vec_out[3:1] when status_high is 0. When status_high is 1, code bits 2,1,0 go into vec_out bits 4,5,6. All other bits come from the stored vector. The codes are: A special 111, A receive 110, A external 101, A transmit 100, B special 011, B receive 010, B external 001, B transmit 000, and none 011.
- R11: Priority, highest first: A special, A receive, A transmit, A external, then the same order for B.
- R12: irq stays 1 while any enabled condition is pending, and it returns to 0 once all are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low hardware reset |
| wr_en | input | 1 | register write strobe |
| wr_ch | input | 1 | channel selected by the write (0 = A) |
| wr_addr | input | 3 | register address |
| wr_data | input | 8 | register write data |
| rx_avail | input | 2 | receive FIFO holds a character, per channel |
| rx_par_err | input | 2 | head character parity mismatch |
| rx_ovr | input | 2 | head character overrun |
| rx_eof | input | 2 | head character ends a frame |
| rx_pop_req | input | 2 | host request to read the FIFO head |
| rx_pop | output | 2 | gated FIFO read |
| tx_empty | input | 2 | transmit buffer became empty (pulse) |
| tx_load | input | 2 | transmit buffer written (pulse) |
| ext_evt | input | 12 | external/status event pulses, six per channel, B in the upper half |
| int_ack | input | 1 | interrupt acknowledge cycle |
| irq | output | 1 | registered interrupt request level |
| vec_out | output | 8 | vector driven during acknowledge |
| vec_reg | output | 8 | stored shared vector |

## Verification
The vector path is tried with random stored vectors, random vis/status_high settings and one random pending source at a time. This tells apart a wrong code value, a wrong bit placement and the wrong status group. Directed pairs of pending sources across both channels check the priority order. The receive sequences check a clean character, an overrun, an end of frame and a parity error with each enable combination. They tell a frozen head from a passing one and show that exactly one read is released after the error reset. Sequences that toggle enables one at a time separate the master enable from the per-source enables, and show that a channel reset acts on its own channel only.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
   localparam int VEC_W  = 8;
   localparam int CODE_W = 3;

   typedef enum logic [1:0] {
      RXM_OFF  = 2'b00,
      RXM_ALLA = 2'b01,
      RXM_ALLB = 2'b10,
      RXM_SPEC = 2'b11
   } rx_mode_e;

   localparam logic [2:0] ADR_CTL  = 3'd0;
   localparam logic [2:0] ADR_PAR  = 3'd1;
   localparam logic [2:0] ADR_XEN  = 3'd2;
   localparam logic [2:0] ADR_VEC  = 3'd3;
   localparam logic [2:0] ADR_VCTL = 3'd4;
   localparam logic [2:0] ADR_CMD  = 3'd5;

   localparam int CMD_ERR = 0;
   localparam int CMD_TX  = 1;
   localparam int CMD_EXT = 2;
   localparam int CMD_RST = 3;

   localparam logic [CODE_W-1:0] CODE_NONE = 3'b011;

   typedef struct packed {
      logic ext;
      logic tx;
      logic rx;
      logic spec;
   } pend_t;

   // kind index: 0 special, 1 receive, 2 transmit, 3 external
   function automatic logic [1:0] kind_code(input int kind);
      case (kind)
         0:       return 2'b11;
         1:       return 2'b10;
         2:       return 2'b00;
         default: return 2'b01;
      endcase
   endfunction
endpackage

// File: rtl/sio_irq_chan.sv
module sio_irq_chan
   import sio_irq_pkg::*;
#(
   parameter int NSRC = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_sel,
   input  logic [2:0]      wr_addr,
   input  logic [7:0]      wr_data,
   input  logic            rx_avail,
   input  logic            rx_par_err,
   input  logic            rx_ovr,
   input  logic            rx_eof,
   input  logic            rx_pop_req,
   output logic            rx_pop,
   input  logic            tx_empty,
   input  logic            tx_load,
   input  logic [NSRC-1:0] ext_evt,
   output pend_t           pend,
   output logic            hold
);
   rx_mode_e        mode_q;
   logic            parsp_q, paren_q, txie_q, mie_q;
   logic [NSRC-1:0] xen_q, xip_q;
   logic            txip_q, hold_q, rel_q;

   logic wr_ctl, wr_par, wr_xen, wr_cmd;
   logic cmd_err, cmd_tx, cmd_ext, cmd_rst;
   logic head_special, rx_on, freeze_now;
   logic unused_data;

   assign wr_ctl  = wr_sel && (wr_addr == ADR_CTL);
   assign wr_par  = wr_sel && (wr_addr == ADR_PAR);
   assign wr_xen  = wr_sel && (wr_addr == ADR_XEN);
   assign wr_cmd  = wr_sel && (wr_addr == ADR_CMD);
   assign cmd_err = wr_cmd && wr_data[CMD_ERR];
   assign cmd_tx  = wr_cmd && wr_data[CMD_TX];
   assign cmd_ext = wr_cmd && wr_data[CMD_EXT];
   assign cmd_rst = wr_cmd && wr_data[CMD_RST];
   assign unused_data = ^wr_data;

   assign head_special = rx_avail &&
                         (rx_ovr || rx_eof || (rx_par_err && parsp_q && paren_q));
   assign rx_on        = (mode_q != RXM_OFF);
   assign freeze_now   = head_special && rx_on && !rel_q;
   assign rx_pop       = rx_pop_req && !hold_q && !freeze_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= RXM_OFF;
         parsp_q <= 1'b0;
         paren_q <= 1'b0;
         txie_q  <= 1'b0;
         mie_q   <= 1'b0;
         xen_q   <= '0;
         xip_q   <= '0;
         txip_q  <= 1'b0;
         hold_q  <= 1'b0;
         rel_q   <= 1'b0;
      end else if (cmd_rst) begin
         mode_q  <= RXM_OFF;
         parsp_q <= 1'b0;
         txie_q  <= 1'b0;
         mie_q   <= 1'b0;
         xen_q   <= '0;
         xip_q   <= '0;
         txip_q  <= 1'b0;
         hold_q  <= 1'b0;
         rel_q   <= 1'b0;
      end else begin
         if (wr_ctl) begin
            mode_q  <= rx_mode_e'(wr_data[1:0]);
            parsp_q <= wr_data[2];
            txie_q  <= wr_data[3];
            mie_q   <= wr_data[4];
         end
         if (wr_par) paren_q <= wr_data[0];
         if (wr_xen) xen_q   <= wr_data[NSRC-1:0];

         if (cmd_tx || tx_load)      txip_q <= 1'b0;
         else if (tx_empty && txie_q) txip_q <= 1'b1;

         if (cmd_ext) xip_q <= '0;
         else         xip_q <= xip_q | (ext_evt & xen_q & {NSRC{mie_q}});

         if (cmd_err)         hold_q <= 1'b0;
         else if (freeze_now) hold_q <= 1'b1;

         if (rx_pop)       rel_q <= 1'b0;
         else if (cmd_err) rel_q <= hold_q;
      end
   end

   assign pend.spec = hold_q;
   assign pend.rx   = rx_avail && !head_special &&
                      ((mode_q == RXM_ALLA) || (mode_q == RXM_ALLB));
   assign pend.tx   = txip_q;
   assign pend.ext  = |xip_q;
   assign hold      = hold_q;
endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio
   import sio_irq_pkg::*;
#(
   parameter int NCH = 2
) (
   input  logic [4*NCH-1:0]  req,
   output logic              any,
   output logic [CODE_W-1:0] code
);
   localparam int NREQ = 4 * NCH;

   always_comb begin
      any  = |req;
      code = CODE_NONE;
      for (int k = NREQ - 1; k >= 0; k--) begin
         if (req[k]) code = {((k / 4) == 0), kind_code(k % 4)};
      end
   end
endmodule

// File: rtl/sio_irq_vec.sv
module sio_irq_vec
   import sio_irq_pkg::*;
(
   input  logic [VEC_W-1:0]  vec,
   input  logic [CODE_W-1:0] code,
   input  logic              vis,
   input  logic              sh,
   input  logic              ack,
   output logic [VEC_W-1:0]  vec_out
);
   logic [VEC_W-1:0] mod;

   always_comb begin
      mod = vec;
      if (vis) begin
         if (sh) begin
            for (int b = 0; b < CODE_W; b++) mod[4 + b] = code[CODE_W - 1 - b];
         end else begin
            mod[3:1] = code;
         end
      end
      vec_out = ack ? mod : '0;
   end
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
   import sio_irq_pkg::*;
#(
   parameter int NCH  = 2,
   parameter int NSRC = 6,
   localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [CH_W-1:0]      wr_ch,
   input  logic [2:0]           wr_addr,
   input  logic [7:0]           wr_data,
   input  logic [NCH-1:0]       rx_avail,
   input  logic [NCH-1:0]       rx_par_err,
   input  logic [NCH-1:0]       rx_ovr,
   input  logic [NCH-1:0]       rx_eof,
   input  logic [NCH-1:0]       rx_pop_req,
   output logic [NCH-1:0]       rx_pop,
   input  logic [NCH-1:0]       tx_empty,
   input  logic [NCH-1:0]       tx_load,
   input  logic [NCH*NSRC-1:0]  ext_evt,
   input  logic                 int_ack,
   output logic                 irq,
   output logic [VEC_W-1:0]     vec_out,
   output logic [VEC_W-1:0]     vec_reg
);
   generate
      if (NCH != 2) begin : g_bad_nch
         $error("sio_irq_ctrl: the 3-bit status code covers exactly two channels");
      end
      if (NSRC < 1 || NSRC > 8) begin : g_bad_nsrc
         $error("sio_irq_ctrl: NSRC must be 1 to 8");
      end
   endgenerate

   logic [4*NCH-1:0]  req_flat;
   logic [NCH-1:0]    hold_w;
   logic              any_w;
   logic [CODE_W-1:0] code_w, code_q;
   logic [VEC_W-1:0]  vec_q;
   logic              vis_q, sh_q, irq_q;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      pend_t p;
      sio_irq_chan #(.NSRC(NSRC)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_sel     (wr_en && (wr_ch == CH_W'(c))),
         .wr_addr    (wr_addr),
         .wr_data    (wr_data),
         .rx_avail   (rx_avail[c]),
         .rx_par_err (rx_par_err[c]),
         .rx_ovr     (rx_ovr[c]),
         .rx_eof     (rx_eof[c]),
         .rx_pop_req (rx_pop_req[c]),
         .rx_pop     (rx_pop[c]),
         .tx_empty   (tx_empty[c]),
         .tx_load    (tx_load[c]),
         .ext_evt    (ext_evt[c*NSRC +: NSRC]),
         .pend       (p),
         .hold       (hold_w[c])
      );
      assign req_flat[c*4 +: 4] = {p.ext, p.tx, p.rx, p.spec};
   end

   sio_irq_prio #(.NCH(NCH)) u_prio (
      .req  (req_flat),
      .any  (any_w),
      .code (code_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q  <= '0;
         vis_q  <= 1'b0;
         sh_q   <= 1'b0;
         irq_q  <= 1'b0;
         code_q <= CODE_NONE;
      end else begin
         if (wr_en && wr_addr == ADR_VEC) vec_q <= wr_data;
         if (wr_en && wr_addr == ADR_VCTL) begin
            vis_q <= wr_data[0];
            sh_q  <= wr_data[1];
         end
         irq_q  <= any_w;
         code_q <= code_w;
      end
   end

   sio_irq_vec u_vec (
      .vec     (vec_q),
      .code    (code_q),
      .vis     (vis_q),
      .sh      (sh_q),
      .ack     (int_ack),
      .vec_out (vec_out)
   );

   assign irq     = irq_q;
   assign vec_reg = vec_q;
endmodule

// File: rtl/sio_irq_chk.sv
module sio_irq_chk #(
   parameter int NCH = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           wr_en,
   input logic [NCH-1:0] rx_pop,
   input logic [NCH-1:0] rx_pop_req,
   input logic [NCH-1:0] hold,
   input logic           int_ack,
   input logic [7:0]     vec_out,
   input logic [7:0]     vec_reg,
   input logic           vis,
   input logic           sh
);
   AST_POP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop & ~rx_pop_req) == '0); // R3
   AST_HOLD_BLOCKS_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (hold & rx_pop) == '0); // R3
   for (genvar c = 0; c < NCH; c++) begin : g_c
      AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         hold[c] && !wr_en |=> hold[c]); // R3
   end
   AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !int_ack |-> vec_out == 8'h00); // R9
   AST_VEC_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack && !vis |-> vec_out == vec_reg); // R9
   AST_VEC_LOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack && vis && !sh |-> {vec_out[7:4], vec_out[0]} == {vec_reg[7:4], vec_reg[0]}); // R10
   AST_VEC_HIGH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack && vis && sh |-> {vec_out[7], vec_out[3:0]} == {vec_reg[7], vec_reg[3:0]}); // R10
endmodule

bind sio_irq_ctrl sio_irq_chk #(.NCH(NCH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .rx_pop     (rx_pop),
   .rx_pop_req (rx_pop_req),
   .hold       (hold_w),
   .int_ack    (int_ack),
   .vec_out    (vec_out),
   .vec_reg    (vec_reg),
   .vis        (vis_q),
   .sh         (sh_q)
);

// File: tb/tb_sio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_sio_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [0:0]  wr_ch = '0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [1:0]  rx_avail = '0, rx_par_err = '0, rx_ovr = '0, rx_eof = '0, rx_pop_req = '0;
   logic [1:0]  rx_pop;
   logic [1:0]  tx_empty = '0, tx_load = '0;
   logic [11:0] ext_evt = '0;
   logic        int_ack = 1'b0;
   logic        irq;
   logic [7:0]  vec_out, vec_reg;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   sio_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_addr(wr_addr),
      .wr_data(wr_data), .rx_avail(rx_avail), .rx_par_err(rx_par_err),
      .rx_ovr(rx_ovr), .rx_eof(rx_eof), .rx_pop_req(rx_pop_req), .rx_pop(rx_pop),
      .tx_empty(tx_empty), .tx_load(tx_load), .ext_evt(ext_evt), .int_ack(int_ack),
      .irq(irq), .vec_out(vec_out), .vec_reg(vec_reg)
   );

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wreg(int ch, logic [2:0] a, logic [7:0] d);
      wr_en = 1'b1; wr_ch = 1'(ch); wr_addr = a; wr_data = d;
      tick(1);
      wr_en = 1'b0;
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // code per source index s = ch*4 + kind (0 spec, 1 rx, 2 tx, 3 ext)
   function automatic logic [2:0] src_code(int s);
      logic [1:0] k;
      case (s % 4)
         0: k = 2'b11;
         1: k = 2'b10;
         2: k = 2'b00;
         default: k = 2'b01;
      endcase
      return {(s / 4) == 0, k};
   endfunction

   function automatic logic [7:0] exp_vec(logic [7:0] v, logic [2:0] c, bit vis, bit sh);
      logic [7:0] r = v;
      if (vis && !sh) r[3:1] = c;
      if (vis && sh) begin r[4] = c[2]; r[5] = c[1]; r[6] = c[0]; end
      return r;
   endfunction

   task automatic make_pending(int s);
      int ch = s / 4;
      case (s % 4)
         0: begin wreg(ch, 3'd0, 8'h03); rx_avail[ch] = 1'b1; rx_ovr[ch] = 1'b1; end
         1: begin wreg(ch, 3'd0, 8'h01); rx_avail[ch] = 1'b1; end
         2: begin wreg(ch, 3'd0, 8'h08); tx_empty[ch] = 1'b1; tick(1); tx_empty[ch] = 1'b0; end
         default: begin
            wreg(ch, 3'd0, 8'h10); wreg(ch, 3'd2, 8'h3F);
            ext_evt[ch*6 + 2] = 1'b1; tick(1); ext_evt = '0;
         end
      endcase
      tick(3);
   endtask

   task automatic clear_all();
      rx_avail = '0; rx_ovr = '0; rx_eof = '0; rx_par_err = '0; rx_pop_req = '0;
      wreg(0, 3'd5, 8'h08);
      wreg(1, 3'd5, 8'h08);
      tick(3);
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      bit vis, sh;
      int s;
      void'($urandom(32'd1234));
      tick(4);
      rst_n = 1'b1;
      tick(2);

      // R1 reset state
      chk("R1 irq after reset", irq, 0);
      chk("R1 vec_reg after reset", vec_reg, 0);
      rx_pop_req[0] = 1'b1; rx_avail[0] = 1'b1; rx_ovr[0] = 1'b1; #1;
      chk("R1 mode off passes read", rx_pop[0], 1);
      tick(3);
      chk("R1 mode off no irq", irq, 0);
      clear_all();

      // R2 special-only mode, clean character
      wreg(0, 3'd0, 8'h03);
      rx_avail[0] = 1'b1; rx_pop_req[0] = 1'b1; #1;
      chk("R2 clean char readable", rx_pop[0], 1);
      tick(4);
      chk("R2 clean char no irq", irq, 0);
      rx_pop_req[0] = 1'b0;

      // R3 overrun freezes head
      rx_ovr[0] = 1'b1; rx_pop_req[0] = 1'b1; #1;
      chk("R3 freeze same cycle", rx_pop[0], 0);
      tick(3);
      chk("R3 special irq", irq, 1);
      int_ack = 1'b1; #1;
      chk("R11 A special code", vec_out, 8'h00);
      int_ack = 1'b0;
      tick(5);
      chk("R3 still frozen", rx_pop[0], 0);
      chk("R12 irq held", irq, 1);
      rx_pop_req[0] = 1'b0;
      wreg(0, 3'd5, 8'h01);
      rx_pop_req[0] = 1'b1; #1;
      chk("R3 released read", rx_pop[0], 1);
      tick(1);
      rx_pop_req[0] = 1'b0; rx_avail[0] = 1'b0; rx_ovr[0] = 1'b0;
      tick(2);
      chk("R3 irq falls after release", irq, 0);
      // end of frame also special, and a second special head refreezes
      rx_avail[0] = 1'b1; rx_eof[0] = 1'b1; rx_pop_req[0] = 1'b1; #1;
      chk("R3 eof freezes", rx_pop[0], 0);
      tick(3);
      chk("R3 eof irq", irq, 1);
      clear_all();

      // R4 parity qualification
      wreg(0, 3'd0, 8'h07);             // special-only, par_special
      rx_avail[0] = 1'b1; rx_par_err[0] = 1'b1; rx_pop_req[0] = 1'b1; #1;
      chk("R4 parity check off ignored read", rx_pop[0], 1);
      tick(3);
      chk("R4 parity check off ignored irq", irq, 0);
      wreg(0, 3'd1, 8'h01);
      tick(3);
      chk("R4 parity special irq", irq, 1);
      chk("R4 parity special frozen", rx_pop[0], 0);
      clear_all();
      wreg(0, 3'd0, 8'h03);             // par_special 0, parity check still on
      rx_avail[0] = 1'b1; rx_par_err[0] = 1'b1; rx_pop_req[0] = 1'b1; #1;
      chk("R4 par_special off readable", rx_pop[0], 1);
      tick(3);
      chk("R4 par_special off no irq", irq, 0);
      wreg(0, 3'd1, 8'h00);
      clear_all();

      // R5 all-character modes
      wreg(1, 3'd0, 8'h02);
      rx_avail[1] = 1'b1;
      tick(3);
      chk("R5 mode 10 irq", irq, 1);
      int_ack = 1'b1; #1;
      chk("R5 B receive vector plain", vec_out, 8'h00);
      int_ack = 1'b0;
      rx_avail[1] = 1'b0;
      tick(3);
      chk("R5 irq clears when empty", irq, 0);
      wreg(1, 3'd0, 8'h00);
      rx_avail[1] = 1'b1;
      tick(3);
      chk("R5 mode 00 no irq", irq, 0);
      clear_all();

      // R6 transmit
      tx_empty[0] = 1'b1; tick(1); tx_empty[0] = 1'b0; tick(3);
      chk("R6 tx_ie off no irq", irq, 0);
      wreg(0, 3'd0, 8'h08);
      tx_empty[0] = 1'b1; tick(1); tx_empty[0] = 1'b0; tick(3);
      chk("R6 tx irq", irq, 1);
      tx_load[0] = 1'b1; tick(1); tx_load[0] = 1'b0; tick(3);
      chk("R6 tx_load clears", irq, 0);
      tx_empty[0] = 1'b1; tick(1); tx_empty[0] = 1'b0; tick(3);
      wreg(0, 3'd5, 8'h02); tick(3);
      chk("R6 tx reset clears", irq, 0);
      clear_all();

      // R7 external gating
      wreg(0, 3'd0, 8'h10); wreg(0, 3'd2, 8'h00);
      ext_evt[1] = 1'b1; tick(1); ext_evt = '0; tick(3);
      chk("R7 source disabled", irq, 0);
      wreg(0, 3'd0, 8'h00); wreg(0, 3'd2, 8'h02);
      ext_evt[1] = 1'b1; tick(1); ext_evt = '0; tick(3);
      chk("R7 master disabled", irq, 0);
      wreg(0, 3'd0, 8'h10);
      ext_evt[1] = 1'b1; tick(1); ext_evt = '0; tick(3);
      chk("R7 both enabled", irq, 1);
      wreg(0, 3'd5, 8'h04); tick(3);
      chk("R7 ext reset clears", irq, 0);

      // R8 channel reset clears master enable only on its channel
      wreg(0, 3'd5, 8'h08);
      wreg(0, 3'd2, 8'h02);
      ext_evt[1] = 1'b1; tick(1); ext_evt = '0; tick(3);
      chk("R8 master cleared by channel reset", irq, 0);
      wreg(0, 3'd0, 8'h08); wreg(1, 3'd0, 8'h08);
      tx_empty = 2'b11; tick(1); tx_empty = '0; tick(3);
      wreg(0, 3'd5, 8'h08); tick(3);
      chk("R8 other channel kept", irq, 1);
      wreg(0, 3'd4, 8'h01);
      int_ack = 1'b1; #1;
      chk("R8 remaining is B transmit", vec_out, 8'h00);
      int_ack = 1'b0;
      clear_all();

      // R9 shared vector
      wreg(1, 3'd3, 8'hA5);
      chk("R9 write via B", vec_reg, 8'hA5);
      wreg(0, 3'd4, 8'h00);
      wreg(0, 3'd3, 8'h5A);
      chk("R9 write via A", vec_reg, 8'h5A);
      chk("R9 idle vector zero", vec_out, 8'h00);
      int_ack = 1'b1; #1;
      chk("R9 vis off unchanged", vec_out, 8'h5A);
      int_ack = 1'b0;

      // R11 priority pairs, vis low, vector 0
      wreg(0, 3'd3, 8'h00); wreg(0, 3'd4, 8'h01);
      make_pending(2); make_pending(4);
      int_ack = 1'b1; #1;
      chk("R11 A tx over B special", vec_out, {4'h0, 3'b100, 1'b0});
      int_ack = 1'b0;
      clear_all();
      make_pending(1); make_pending(4);
      int_ack = 1'b1; #1;
      chk("R11 A rx over B special", vec_out, {4'h0, 3'b110, 1'b0});
      int_ack = 1'b0;
      clear_all();
      make_pending(3); make_pending(2);
      int_ack = 1'b1; #1;
      chk("R11 A tx over A ext", vec_out, {4'h0, 3'b100, 1'b0});
      int_ack = 1'b0;
      clear_all();
      make_pending(7); make_pending(6);
      int_ack = 1'b1; #1;
      chk("R11 B tx over B ext", vec_out, {4'h0, 3'b000, 1'b0});
      int_ack = 1'b0;
      clear_all();

      // R10 random vector modification, one source at a time
      for (int i = 0; i < 48; i++) begin
         v = 8'($urandom);
         vis = 1'($urandom); sh = 1'($urandom);
         s = int'($urandom % 8);
         wreg(int'($urandom % 2), 3'd3, v);
         wreg(int'($urandom % 2), 3'd4, {6'd0, sh, vis});
         make_pending(s);
         chk("R12 irq with one source", irq, 1);
         int_ack = 1'b1; #1;
         chk("R10 modified vector", vec_out, exp_vec(v, src_code(s), vis, sh));
         int_ack = 1'b0;
         clear_all();
         chk("R12 irq cleared", irq, 0);
      end

      // R10 no-pending code
      wreg(0, 3'd3, 8'h00); wreg(0, 3'd4, 8'h01);
      int_ack = 1'b1; #1;
      chk("R10 none code", vec_out, 8'h06);
      int_ack = 1'b0;

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule